// File: doc/BRIEF.md
# Processor Core Arithmetic and Flag Unit

This block is the integer execution stage of a small processor core. Each cycle it takes a decoded instruction and two operands and produces a result in the same cycle. The instruction is a 6-bit opcode plus four control bits: write zero flag, write carry flag, write result, and immediate select. The operands are a destination value D and a source value S. The block also holds the core's zero (Z) and carry (C) flags and updates them on the rising clock edge. The surrounding core commits the result to its register file when the block raises the result write strobe.

All arithmetic goes through one adder/subtractor. That covers plain, carry-chained (multi-word), signed, compare, limit (minimum/maximum) and magnitude add/subtract operations. A separate bitwise unit handles AND, AND-NOT, OR and XOR. A third unit handles the move, negate and absolute-value family.

The meaning of C depends on the opcode. It can be the unsigned carry or borrow, the signed overflow, a signed less-than, the parity of the result, or the sign bit of S. For chained operations, Z can only stay set across words, so a multi-word zero test or equality test works word by word. Opcodes outside this set are ignored.

Top module: `cog_alu`

## Requirements
- R1: While the active-low reset is asserted, both flag outputs z_o and c_o read 0.
- R2: result_we_o equals wr_i for supported opcodes. For any opcode not listed in R5 to R11 (for example 001000), result_we_o stays 0 and neither flag changes, whatever wz_i, wc_i and wr_i are.
- R3: Z takes its new value only in a cycle with wz_i set. C takes its new value only in a cycle with wc_i set. Otherwise each flag keeps its value.
- R4: With imm_i set, S is bits [8:0] of s_i zero-extended to 32 bits, and bits [31:9] of s_i have no effect.
- R5: Opcode 100000 gives D+S, with C = unsigned carry out. Opcode 100001 gives D-S, with C = 1 when D < S unsigned. In both cases Z = 1 when the 32-bit result is zero, and with wr_i clear 100001 acts as a compare.
- R6: Opcode 110010 gives D+S+C and sets C to the carry. Opcode 110011 gives D-(S+C) and sets C when D < S+C unsigned. In both, the new Z is the old Z AND (result is zero).
- R7: Opcodes 110100 (D+S), 110101 (D-S), 110110 (D+S+C) and 110111 (D-(S+C)) set C to signed overflow. Opcode 110000 gives D-S with C = signed D < S and Z = (D equals S). Opcode 110001 gives D-(S+C) with C = signed D < S+C. For 110110, 110111 and 110001, Z is chained as in R6.
- R8: Opcodes 011000 (D AND S), 011001 (D AND NOT S), 011010 (D OR S) and 011011 (D XOR S) set Z when the result is zero, and set C to 1 when the result has an odd number of one bits.
- R9: Opcodes 010000 and 010010 return S when D < S and D otherwise. Opcodes 010001 and 010011 return D when D < S and S otherwise. The compare is signed for 010000 and 010001 and unsigned for 010010 and 010011. C is that D < S test, and Z = 1 when S is zero.
- R10: Opcode 101000 returns S, 101001 returns -S, and 101010 returns the two's-complement magnitude of S. For all three, C = bit 31 of S and Z = 1 when the result is zero.
- R11: Opcode 100010 returns D+|S| and 100011 returns D-|S|. For non-negative S, C is the unsigned carry (100010) or the unsigned borrow (100011). For negative S, C is the inverse of the borrow of D-S (100010) or the inverse of the carry of D+S (100011), where S is taken as raw bits.
- R12: result_o and result_we_o follow the inputs in the same cycle. The flag outputs change only at the rising clock edge after the instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 6 | Operation code |
| wz_i | input | 1 | Write enable for the zero flag |
| wc_i | input | 1 | Write enable for the carry flag |
| wr_i | input | 1 | Request to commit the result |
| imm_i | input | 1 | Take S from the low 9 bits of s_i, zero-extended |
| d_i | input | 32 | Destination operand D |
| s_i | input | 32 | Source operand S or immediate field |
| result_o | output | 32 | Combinational result |
| result_we_o | output | 1 | Result write strobe |
| z_o | output | 1 | Registered zero flag |
| c_o | output | 1 | Registered carry flag |

## Verification
The bench builds a 64-bit add and two 64-bit compares from chained words. In the second compare the high words give a zero result but the low words did not. A design that recomputes Z instead of chaining it would report equality there.

Signed and unsigned variants get operands such as all-ones against one. Here the two orders disagree, so a limit or compare that uses the wrong signedness returns the other operand or the opposite carry. Overflow is tested at both ends of the signed range, and the magnitude of the most negative value is checked for wrap-around.

Magnitude add and subtract are run with negative S, where C is inverted. Moves use an immediate with garbage in the upper source bits. The bench also checks that flags hold with their write bits clear and with an unsupported opcode; a design that leaks there would change the flags or raise a write strobe.

// File: rtl/cog_alu_pkg.sv
package cog_alu_pkg;

   localparam int OP_W = 6;

   typedef logic [OP_W-1:0] op_t;

   localparam op_t OP_MINS   = 6'b010000;
   localparam op_t OP_MAXS   = 6'b010001;
   localparam op_t OP_MIN    = 6'b010010;
   localparam op_t OP_MAX    = 6'b010011;
   localparam op_t OP_AND    = 6'b011000;
   localparam op_t OP_ANDN   = 6'b011001;
   localparam op_t OP_OR     = 6'b011010;
   localparam op_t OP_XOR    = 6'b011011;
   localparam op_t OP_ADD    = 6'b100000;
   localparam op_t OP_SUB    = 6'b100001;
   localparam op_t OP_ADDABS = 6'b100010;
   localparam op_t OP_SUBABS = 6'b100011;
   localparam op_t OP_MOV    = 6'b101000;
   localparam op_t OP_NEG    = 6'b101001;
   localparam op_t OP_ABS    = 6'b101010;
   localparam op_t OP_CMPS   = 6'b110000;
   localparam op_t OP_CMPSX  = 6'b110001;
   localparam op_t OP_ADDX   = 6'b110010;
   localparam op_t OP_SUBX   = 6'b110011;
   localparam op_t OP_ADDS   = 6'b110100;
   localparam op_t OP_SUBS   = 6'b110101;
   localparam op_t OP_ADDSX  = 6'b110110;
   localparam op_t OP_SUBSX  = 6'b110111;

   // source of the carry flag
   typedef enum logic [2:0] {
      CF_CARRY  = 3'd0,   // adder carry / borrow
      CF_OVF    = 3'd1,   // signed overflow
      CF_SLT    = 3'd2,   // signed less-than
      CF_ABSX   = 3'd3,   // magnitude add/sub, inverted for negative S
      CF_PARITY = 3'd4,   // odd parity of result
      CF_SSIGN  = 3'd5    // sign bit of S
   } cflag_sel_e;

   // source of the zero flag
   typedef enum logic [1:0] {
      ZF_RES   = 2'd0,    // result is zero
      ZF_CHAIN = 2'd1,    // old Z and result is zero
      ZF_SZERO = 2'd2     // S is zero
   } zflag_sel_e;

   // result mux select
   typedef enum logic [2:0] {
      RS_PASS   = 3'd0,
      RS_ADDER  = 3'd1,
      RS_LOGIC  = 3'd2,
      RS_LIMIT  = 3'd3,
      RS_UNARY  = 3'd4
   } res_sel_e;

   typedef struct packed {
      logic       valid;
      logic       sub;
      logic       use_cin;
      logic       abs_dir;
      res_sel_e   rsel;
      cflag_sel_e csel;
      zflag_sel_e zsel;
      logic       lim_signed;
      logic       lim_upper;
      logic [1:0] log_op;
      logic [1:0] un_op;
   } ctrl_t;

endpackage

// File: rtl/cog_alu_decode.sv
module cog_alu_decode
   import cog_alu_pkg::*;
(
   input  logic [OP_W-1:0] op_i,
   output ctrl_t           ctrl_o
);

   always_comb begin
      ctrl_o            = '0;
      ctrl_o.rsel       = RS_PASS;
      ctrl_o.csel       = CF_CARRY;
      ctrl_o.zsel       = ZF_RES;
      ctrl_o.log_op     = op_i[1:0];
      ctrl_o.un_op      = op_i[1:0];
      unique case (op_i)
         OP_ADD: begin
            ctrl_o.valid = 1'b1;
            ctrl_o.rsel  = RS_ADDER;
         end
         OP_SUB: begin
            ctrl_o.valid = 1'b1;
            ctrl_o.sub   = 1'b1;
            ctrl_o.rsel  = RS_ADDER;
         end
         OP_ADDX: begin
            ctrl_o.valid   = 1'b1;
            ctrl_o.use_cin = 1'b1;
            ctrl_o.rsel    = RS_ADDER;
            ctrl_o.zsel    = ZF_CHAIN;
         end
         OP_SUBX: begin
            ctrl_o.valid   = 1'b1;
            ctrl_o.sub     = 1'b1;
            ctrl_o.use_cin = 1'b1;
            ctrl_o.rsel    = RS_ADDER;
            ctrl_o.zsel    = ZF_CHAIN;
         end
         OP_ADDS: begin
            ctrl_o.valid = 1'b1;
            ctrl_o.rsel  = RS_ADDER;
            ctrl_o.csel  = CF_OVF;
         end
         OP_SUBS: begin
            ctrl_o.valid = 1'b1;
            ctrl_o.sub   = 1'b1;
            ctrl_o.rsel  = RS_ADDER;
            ctrl_o.csel  = CF_OVF;
         end
         OP_ADDSX: begin
            ctrl_o.valid   = 1'b1;
            ctrl_o.use_cin = 1'b1;
            ctrl_o.rsel    = RS_ADDER;
            ctrl_o.csel    = CF_OVF;
            ctrl_o.zsel    = ZF_CHAIN;
         end
         OP_SUBSX: begin
            ctrl_o.valid   = 1'b1;
            ctrl_o.sub     = 1'b1;
            ctrl_o.use_cin = 1'b1;
            ctrl_o.rsel    = RS_ADDER;
            ctrl_o.csel    = CF_OVF;
            ctrl_o.zsel    = ZF_CHAIN;
         end
         OP_CMPS: begin
            ctrl_o.valid = 1'b1;
            ctrl_o.sub   = 1'b1;
            ctrl_o.rsel  = RS_ADDER;
            ctrl_o.csel  = CF_SLT;
         end
         OP_CMPSX: begin
            ctrl_o.valid   = 1'b1;
            ctrl_o.sub     = 1'b1;
            ctrl_o.use_cin = 1'b1;
            ctrl_o.rsel    = RS_ADDER;
            ctrl_o.csel    = CF_SLT;
            ctrl_o.zsel    = ZF_CHAIN;
         end
         OP_AND, OP_ANDN, OP_OR, OP_XOR: begin
            ctrl_o.valid = 1'b1;
            ctrl_o.rsel  = RS_LOGIC;
            ctrl_o.csel  = CF_PARITY;
         end
         OP_MINS, OP_MAXS: begin
            ctrl_o.valid      = 1'b1;
            ctrl_o.sub        = 1'b1;
            ctrl_o.rsel       = RS_LIMIT;
            ctrl_o.csel       = CF_SLT;
            ctrl_o.zsel       = ZF_SZERO;
            ctrl_o.lim_signed = 1'b1;
            ctrl_o.lim_upper  = (op_i == OP_MINS);
         end
         OP_MIN, OP_MAX: begin
            ctrl_o.valid     = 1'b1;
            ctrl_o.sub       = 1'b1;
            ctrl_o.rsel      = RS_LIMIT;
            ctrl_o.csel      = CF_CARRY;
            ctrl_o.zsel      = ZF_SZERO;
            ctrl_o.lim_upper = (op_i == OP_MIN);
         end
         OP_MOV, OP_NEG, OP_ABS: begin
            ctrl_o.valid = 1'b1;
            ctrl_o.rsel  = RS_UNARY;
            ctrl_o.csel  = CF_SSIGN;
         end
         OP_ADDABS: begin
            ctrl_o.valid   = 1'b1;
            ctrl_o.abs_dir = 1'b1;
            ctrl_o.rsel    = RS_ADDER;
            ctrl_o.csel    = CF_ABSX;
         end
         OP_SUBABS: begin
            ctrl_o.valid   = 1'b1;
            ctrl_o.abs_dir = 1'b1;
            ctrl_o.sub     = 1'b1;
            ctrl_o.rsel    = RS_ADDER;
            ctrl_o.csel    = CF_ABSX;
         end
         default: ctrl_o.valid = 1'b0;
      endcase
   end

endmodule

// File: rtl/cog_alu_addsub.sv
module cog_alu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o,
   output logic         ovf_o,
   output logic         slt_o
);

   localparam int MSB = W - 1;

   logic [W:0] wide;
   logic       sign_a;
   logic       sign_b;
   logic       sign_r;

   always_comb begin
      if (sub_i) begin
         wide = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
      end else begin
         wide = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
      end
   end

   assign sum_o  = wide[MSB:0];
   assign cout_o = wide[W];

   assign sign_a = a_i[MSB];
   assign sign_b = b_i[MSB];
   assign sign_r = wide[MSB];

   // overflow: operand signs agree (add) or disagree (sub) and result flips
   assign ovf_o = (sub_i ? (sign_a ^ sign_b) : ~(sign_a ^ sign_b)) & (sign_r ^ sign_a);
   // true sign of the exact difference
   assign slt_o = sign_r ^ ovf_o;

endmodule

// File: rtl/cog_alu_bitwise.sv
module cog_alu_bitwise #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [1:0]   fn_i,
   output logic [W-1:0] res_o,
   output logic         parity_o
);

   always_comb begin
      unique case (fn_i)
         2'b00:   res_o = a_i & b_i;
         2'b01:   res_o = a_i & ~b_i;
         2'b10:   res_o = a_i | b_i;
         default: res_o = a_i ^ b_i;
      endcase
   end

   assign parity_o = ^res_o;

endmodule

// File: rtl/cog_alu_unary.sv
module cog_alu_unary #(
   parameter int W = 32
) (
   input  logic [W-1:0] s_i,
   input  logic [1:0]   fn_i,
   output logic [W-1:0] res_o
);

   localparam int MSB = W - 1;

   logic [W-1:0] negated;

   assign negated = '0 - s_i;

   always_comb begin
      unique case (fn_i)
         2'b01:   res_o = negated;
         2'b10:   res_o = s_i[MSB] ? negated : s_i;
         default: res_o = s_i;
      endcase
   end

endmodule

// File: rtl/cog_alu.sv
module cog_alu
   import cog_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   op_i,
   input  logic              wz_i,
   input  logic              wc_i,
   input  logic              wr_i,
   input  logic              imm_i,
   input  logic [DATA_W-1:0] d_i,
   input  logic [DATA_W-1:0] s_i,
   output logic [DATA_W-1:0] result_o,
   output logic              result_we_o,
   output logic              z_o,
   output logic              c_o
);

   localparam int MSB = DATA_W - 1;

   // elaboration-time parameter checks
   if (DATA_W < 8) begin : g_chk_data_w
      $error("cog_alu: DATA_W must be at least 8");
   end
   if (IMM_W < 1 || IMM_W > DATA_W) begin : g_chk_imm_w
      $error("cog_alu: IMM_W must lie in 1..DATA_W");
   end

   ctrl_t             ctrl;
   logic [DATA_W-1:0] s_eff;
   logic              z_q;
   logic              c_q;

   // immediate source selection
   if (IMM_W < DATA_W) begin : g_imm_ext
      assign s_eff = imm_i ? {{(DATA_W - IMM_W){1'b0}}, s_i[IMM_W-1:0]} : s_i;
   end else begin : g_imm_full
      logic unused_imm;
      assign unused_imm = imm_i;
      assign s_eff      = s_i;
   end

   cog_alu_decode u_decode (
      .op_i   (op_i),
      .ctrl_o (ctrl)
   );

   // shared adder/subtractor
   logic              sub_eff;
   logic              cin_eff;
   logic [DATA_W-1:0] add_sum;
   logic              add_cout;
   logic              add_ovf;
   logic              add_slt;

   assign sub_eff = ctrl.abs_dir ? (ctrl.sub ^ s_eff[MSB]) : ctrl.sub;
   assign cin_eff = ctrl.use_cin & c_q;

   cog_alu_addsub #(.W(DATA_W)) u_addsub (
      .a_i    (d_i),
      .b_i    (s_eff),
      .sub_i  (sub_eff),
      .cin_i  (cin_eff),
      .sum_o  (add_sum),
      .cout_o (add_cout),
      .ovf_o  (add_ovf),
      .slt_o  (add_slt)
   );

   logic [DATA_W-1:0] log_res;
   logic              log_par;

   cog_alu_bitwise #(.W(DATA_W)) u_bitwise (
      .a_i      (d_i),
      .b_i      (s_eff),
      .fn_i     (ctrl.log_op),
      .res_o    (log_res),
      .parity_o (log_par)
   );

   logic [DATA_W-1:0] un_res;

   cog_alu_unary #(.W(DATA_W)) u_unary (
      .s_i   (s_eff),
      .fn_i  (ctrl.un_op),
      .res_o (un_res)
   );

   // limit (min/max) selection from the adder's compare
   logic              lim_lt;
   logic [DATA_W-1:0] lim_res;

   assign lim_lt  = ctrl.lim_signed ? add_slt : add_cout;
   assign lim_res = ctrl.lim_upper ? (lim_lt ? s_eff : d_i)
                                   : (lim_lt ? d_i : s_eff);

   always_comb begin
      unique case (ctrl.rsel)
         RS_ADDER: result_o = add_sum;
         RS_LOGIC: result_o = log_res;
         RS_LIMIT: result_o = lim_res;
         RS_UNARY: result_o = un_res;
         default:  result_o = d_i;
      endcase
   end

   assign result_we_o = wr_i & ctrl.valid;

   // next flag values
   logic res_zero;
   logic z_calc;
   logic c_calc;

   assign res_zero = (result_o == '0);

   always_comb begin
      unique case (ctrl.zsel)
         ZF_CHAIN: z_calc = z_q & res_zero;
         ZF_SZERO: z_calc = (s_eff == '0);
         default:  z_calc = res_zero;
      endcase
   end

   always_comb begin
      unique case (ctrl.csel)
         CF_OVF:    c_calc = add_ovf;
         CF_SLT:    c_calc = add_slt;
         CF_ABSX:   c_calc = add_cout ^ s_eff[MSB];
         CF_PARITY: c_calc = log_par;
         CF_SSIGN:  c_calc = s_eff[MSB];
         default:   c_calc = add_cout;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         z_q <= 1'b0;
         c_q <= 1'b0;
      end else if (ctrl.valid) begin
         if (wz_i) z_q <= z_calc;
         if (wc_i) c_q <= c_calc;
      end
   end

   assign z_o = z_q;
   assign c_o = c_q;

   // flag and result checks
   AST_Z_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wz_i |=> $stable(z_o)); // R3
   AST_C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wc_i |=> $stable(c_o)); // R3
   AST_CMP_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (wz_i && op_i == OP_SUB) |=> (z_o == ($past(d_i) == $past(s_eff)))); // R5
   AST_CHAIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (wz_i && ctrl.valid && ctrl.zsel == ZF_CHAIN && !z_o) |=> !z_o); // R6
   AST_LIMIT_SZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wz_i && ctrl.valid && ctrl.zsel == ZF_SZERO) |=> (z_o == ($past(s_eff) == '0))); // R9
   AST_MOVE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (wc_i && op_i == OP_MOV) |=> (c_o == $past(s_eff[MSB]))); // R10

endmodule

// File: tb/cog_alu_tb.sv
module cog_alu_tb;

   localparam int CLK_PERIOD = 10;

   localparam logic [5:0] T_MINS = 6'b010000, T_MAXS = 6'b010001,
                          T_MIN  = 6'b010010, T_MAX  = 6'b010011,
                          T_AND  = 6'b011000, T_ANDN = 6'b011001,
                          T_OR   = 6'b011010, T_XOR  = 6'b011011,
                          T_ADD  = 6'b100000, T_SUB  = 6'b100001,
                          T_ADDA = 6'b100010, T_SUBA = 6'b100011,
                          T_MOV  = 6'b101000, T_NEG  = 6'b101001,
                          T_ABS  = 6'b101010, T_CMPS = 6'b110000,
                          T_CMPSX= 6'b110001, T_ADDX = 6'b110010,
                          T_SUBX = 6'b110011, T_ADDS = 6'b110100,
                          T_SUBS = 6'b110101, T_ADDSX= 6'b110110,
                          T_SUBSX= 6'b110111, T_BAD  = 6'b001000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  op = '0;
   logic        wz = 1'b0, wc = 1'b0, wr = 1'b0, im = 1'b0;
   logic [31:0] d = '0, s = '0;
   logic [31:0] res;
   logic        we, zf, cf;

   int checks = 0;
   int errors = 0;
   bit drv_valid = 1'b0;
   bit m_z = 1'b0, m_c = 1'b0;

   typedef struct {
      logic [31:0] res;
      bit          chk_res;
      bit          we;
      bit          z_old, c_old, z_new, c_new;
      string       tag;
   } item_t;

   item_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   cog_alu u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_i        (op),
      .wz_i        (wz),
      .wc_i        (wc),
      .wr_i        (wr),
      .imm_i       (im),
      .d_i         (d),
      .s_i         (s),
      .result_o    (res),
      .result_we_o (we),
      .z_o         (zf),
      .c_o         (cf)
   );

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic item_t model(string tag, logic [5:0] o, bit wzb, bit wcb, bit wrb,
                                   bit imb, logic [31:0] dv, logic [31:0] sr, bit zo, bit co);
      item_t it;
      logic [31:0] sv, r, mag;
      longint du, su, ds, ss, t;
      bit zc, cc, ok;
      sv  = imb ? {23'b0, sr[8:0]} : sr;
      du  = {32'b0, dv};
      su  = {32'b0, sv};
      ds  = $signed(dv);
      ss  = $signed(sv);
      mag = sv[31] ? (32'd0 - sv) : sv;
      ok = 1'b1; r = dv; zc = zo; cc = co; t = 0;
      case (o)
         T_ADD:  begin t = du + su; r = t[31:0]; cc = t[32]; zc = (r == 0); end
         T_SUB:  begin r = dv - sv; cc = (du < su); zc = (dv == sv); end
         T_ADDX: begin t = du + su + longint'(co); r = t[31:0]; cc = t[32]; zc = zo && (r == 0); end
         T_SUBX: begin r = dv - sv - {31'b0, co}; cc = (du < su + longint'(co)); zc = zo && (r == 0); end
         T_ADDS, T_SUBS, T_ADDSX, T_SUBSX: begin
            if (o == T_ADDS)       t = ds + ss;
            else if (o == T_SUBS)  t = ds - ss;
            else if (o == T_ADDSX) t = ds + ss + longint'(co);
            else                   t = ds - ss - longint'(co);
            r  = t[31:0];
            cc = (t > 64'sd2147483647) || (t < -64'sd2147483648);
            zc = (o == T_ADDSX || o == T_SUBSX) ? (zo && (r == 0)) : (r == 0);
         end
         T_CMPS:  begin r = dv - sv; cc = (ds < ss); zc = (dv == sv); end
         T_CMPSX: begin r = dv - sv - {31'b0, co}; cc = (ds < ss + longint'(co)); zc = zo && (r == 0); end
         T_AND, T_ANDN, T_OR, T_XOR: begin
            if (o == T_AND)       r = dv & sv;
            else if (o == T_ANDN) r = dv & ~sv;
            else if (o == T_OR)   r = dv | sv;
            else                  r = dv ^ sv;
            cc = ^r; zc = (r == 0);
         end
         T_MINS:  begin cc = (ds < ss); r = cc ? sv : dv; zc = (sv == 0); end
         T_MAXS:  begin cc = (ds < ss); r = cc ? dv : sv; zc = (sv == 0); end
         T_MIN:   begin cc = (du < su); r = cc ? sv : dv; zc = (sv == 0); end
         T_MAX:   begin cc = (du < su); r = cc ? dv : sv; zc = (sv == 0); end
         T_MOV:   begin r = sv; cc = sv[31]; zc = (r == 0); end
         T_NEG:   begin r = 32'd0 - sv; cc = sv[31]; zc = (r == 0); end
         T_ABS:   begin r = mag; cc = sv[31]; zc = (r == 0); end
         T_ADDA:  begin t = du + su; r = dv + mag; cc = sv[31] ? !(du < su) : t[32]; zc = (r == 0); end
         T_SUBA:  begin t = du + su; r = dv - mag; cc = sv[31] ? !t[32] : (du < su); zc = (r == 0); end
         default: ok = 1'b0;
      endcase
      it.res     = r;
      it.chk_res = ok;
      it.we      = wrb && ok;
      it.z_old   = zo;
      it.c_old   = co;
      it.z_new   = (ok && wzb) ? zc : zo;
      it.c_new   = (ok && wcb) ? cc : co;
      it.tag     = tag;
      return it;
   endfunction

   // driver: one instruction per cycle, expected item into the scoreboard
   task automatic issue(string tag, logic [5:0] o, bit wzb, bit wcb, bit wrb, bit imb,
                        logic [31:0] dv, logic [31:0] sv);
      item_t it;
      it = model(tag, o, wzb, wcb, wrb, imb, dv, sv, m_z, m_c);
      @(negedge clk);
      op = o; wz = wzb; wc = wcb; wr = wrb; im = imb; d = dv; s = sv;
      sb_q.push_back(it);
      drv_valid = 1'b1;
      m_z = it.z_new;
      m_c = it.c_new;
   endtask

   task automatic idle();
      @(negedge clk);
      op = '0; wz = 1'b0; wc = 1'b0; wr = 1'b0; im = 1'b0;
      drv_valid = 1'b0;
   endtask

   // monitor: result mid-cycle, flags after the following edge
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         if (drv_valid && sb_q.size() > 0) begin
            it = sb_q.pop_front();
            if (it.chk_res) check(it.tag, "result", res, it.res);
            check(it.tag, "write strobe", {31'b0, we}, {31'b0, it.we});
            check({it.tag, "/R12"}, "Z before edge", {31'b0, zf}, {31'b0, it.z_old});
            check({it.tag, "/R12"}, "C before edge", {31'b0, cf}, {31'b0, it.c_old});
            @(posedge clk);
            #(CLK_PERIOD/4);
            check(it.tag, "Z", {31'b0, zf}, {31'b0, it.z_new});
            check(it.tag, "C", {31'b0, cf}, {31'b0, it.c_new});
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      checks++;
      errors++;
      $display("FAIL R12 watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "Z in reset", {31'b0, zf}, 32'd0);
      check("R1", "C in reset", {31'b0, cf}, 32'd0);
      rst_n = 1'b1;

      // R5 plain add / subtract / compare
      issue("R5", T_ADD, 1, 1, 1, 0, 32'hFFFF_FFFF, 32'h0000_0001);
      issue("R5", T_SUB, 1, 1, 1, 0, 32'h0000_0005, 32'h0000_0007);
      issue("R5", T_SUB, 1, 1, 0, 0, 32'h0000_0009, 32'h0000_0009);
      // R6 64-bit add and chained compares
      issue("R6", T_ADD,  1, 1, 1, 0, 32'hFFFF_FFFF, 32'h0000_0001);
      issue("R6", T_ADDX, 1, 1, 1, 0, 32'h0000_0000, 32'hFFFF_FFFF);
      issue("R6", T_SUB,  1, 1, 0, 0, 32'h0000_0010, 32'h0000_0010);
      issue("R6", T_SUBX, 1, 1, 0, 0, 32'h0000_0003, 32'h0000_0003);
      issue("R6", T_SUB,  1, 1, 0, 0, 32'h0000_0001, 32'h0000_0002);
      issue("R6", T_SUBX, 1, 1, 0, 0, 32'h0000_0005, 32'h0000_0004);
      issue("R6", T_SUBX, 1, 1, 1, 0, 32'h0000_0000, 32'h0000_0000);
      // R7 signed family
      issue("R7", T_ADDS,  1, 1, 1, 0, 32'h7FFF_FFFF, 32'h0000_0001);
      issue("R7", T_SUBS,  1, 1, 1, 0, 32'h8000_0000, 32'h0000_0001);
      issue("R7", T_ADDSX, 1, 1, 1, 0, 32'h7FFF_FFFE, 32'h0000_0000);
      issue("R7", T_SUBSX, 1, 1, 1, 0, 32'h0000_0000, 32'h7FFF_FFFF);
      issue("R7", T_CMPS,  1, 1, 0, 0, 32'hFFFF_FFFF, 32'h0000_0001);
      issue("R7", T_CMPS,  1, 1, 0, 0, 32'h0000_0004, 32'h0000_0004);
      issue("R7", T_CMPSX, 1, 1, 0, 0, 32'h0000_0004, 32'h0000_0004);
      issue("R7", T_SUBS,  1, 1, 1, 0, 32'h0000_0002, 32'h0000_0001);
      issue("R7", T_CMPSX, 1, 1, 0, 0, 32'h8000_0000, 32'h7FFF_FFFF);
      // R8 bitwise with parity
      issue("R8", T_AND,  1, 1, 1, 0, 32'h0000_F0F0, 32'h0000_0FF0);
      issue("R8", T_ANDN, 1, 1, 1, 0, 32'h0000_F0F0, 32'h0000_0FF0);
      issue("R8", T_OR,   1, 1, 1, 0, 32'h0000_0100, 32'h0000_0003);
      issue("R8", T_XOR,  1, 1, 1, 0, 32'hA5A5_A5A5, 32'hA5A5_A5A5);
      issue("R8", T_AND,  1, 1, 0, 0, 32'h8000_0001, 32'h8000_0000);
      // R9 limits, signed and unsigned disagree
      issue("R9", T_MINS, 1, 1, 1, 0, 32'hFFFF_FFFF, 32'h0000_0001);
      issue("R9", T_MAXS, 1, 1, 1, 0, 32'hFFFF_FFFF, 32'h0000_0001);
      issue("R9", T_MIN,  1, 1, 1, 0, 32'hFFFF_FFFF, 32'h0000_0001);
      issue("R9", T_MAX,  1, 1, 1, 0, 32'hFFFF_FFFF, 32'h0000_0001);
      issue("R9", T_MAXS, 1, 1, 1, 0, 32'h0000_0005, 32'h0000_0000);
      // R4 immediate with garbage upper bits, R10 moves
      issue("R4",  T_MOV, 1, 1, 1, 1, 32'h0000_0000, 32'hFFFF_FE05);
      issue("R4",  T_ADD, 1, 1, 1, 1, 32'h0000_0001, 32'h8000_01FF);
      issue("R10", T_MOV, 1, 1, 1, 0, 32'h1234_5678, 32'h8000_0000);
      issue("R10", T_NEG, 1, 1, 1, 0, 32'h0000_0000, 32'h0000_0000);
      issue("R10", T_ABS, 1, 1, 1, 0, 32'h0000_0000, 32'h8000_0000);
      issue("R10", T_ABS, 1, 1, 1, 0, 32'h0000_0000, 32'hFFFF_FFF6);
      issue("R10", T_NEG, 1, 1, 1, 0, 32'h0000_0000, 32'h0000_0003);
      // R11 magnitude add / subtract
      issue("R11", T_ADDA, 1, 1, 1, 0, 32'h0000_0010, 32'hFFFF_FFFD);
      issue("R11", T_ADDA, 1, 1, 1, 0, 32'hFFFF_FFFF, 32'h0000_0005);
      issue("R11", T_ADDA, 1, 1, 1, 0, 32'hFFFF_FFFF, 32'h8000_0001);
      issue("R11", T_SUBA, 1, 1, 1, 0, 32'h0000_0010, 32'hFFFF_FFFD);
      issue("R11", T_SUBA, 1, 1, 1, 0, 32'h0000_0002, 32'h0000_0005);
      issue("R11", T_SUBA, 1, 1, 1, 0, 32'h0000_0001, 32'hFFFF_FFFB);
      // R3 write enables gate each flag
      issue("R3", T_ADD, 1, 1, 1, 0, 32'hFFFF_FFFF, 32'h0000_0001);
      issue("R3", T_ADD, 0, 0, 1, 0, 32'h0000_0002, 32'h0000_0003);
      issue("R3", T_ADD, 0, 1, 1, 0, 32'h0000_0002, 32'h0000_0003);
      issue("R3", T_SUB, 1, 0, 0, 0, 32'h0000_0001, 32'h0000_0002);
      // R2 unsupported opcode is ignored
      issue("R2", T_ADD, 1, 1, 1, 0, 32'hFFFF_FFFF, 32'h0000_0001);
      issue("R2", T_BAD, 1, 1, 1, 0, 32'h0000_0007, 32'h0000_0001);
      issue("R2", T_BAD, 1, 1, 1, 0, 32'h0000_0000, 32'h0000_0000);
      repeat (3) idle();
      repeat (2) @(negedge clk);

      // R1 reset clears flags that were set
      check("R1", "Z set before reset", {31'b0, zf}, 32'd1);
      check("R1", "C set before reset", {31'b0, cf}, 32'd1);
      rst_n = 1'b0;
      #(CLK_PERIOD/4);
      check("R1", "Z cleared by reset", {31'b0, zf}, 32'd0);
      check("R1", "C cleared by reset", {31'b0, cf}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule